// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer fetch engine and a display pipeline. It takes 32-bit words read from pixel memory and produces one 24-bit colour pixel per cycle. Depending on the depth code, a word holds between one and thirty-two pixels. Indexed depths send each pixel's index out on a palette lookup port and return the colour that comes back in the same cycle. Direct depths widen their packed colour fields to 8 bits per channel inside the block.

The word input and the pixel output are both valid/ready streams. The block holds at most one word. It accepts a new word only when it holds none, or when the final pixel of the held word leaves in that same cycle. While `pix_ready` is low, the presented pixel and `pix_valid` stay unchanged and no word is taken. The depth, ordering, swap and 16-bit layout controls are plain inputs. They are captured together with each word, so changing them affects only words accepted afterwards.

Top module: `fb_unpack`

## Requirements
- R1: After reset `pix_valid` is 0 and `word_ready` is 1. `word_ready` is 1 exactly when no word is held, or when `pix_ready` is 1 and the held word has one pixel left. A word is taken on `word_valid && word_ready`, and its first pixel is presented in the next cycle.
- R2: While `pix_valid` is 1 and `pix_ready` is 0, `pix_valid` stays 1, `pix_data` stays unchanged and `word_ready` is 0.
- R3: `mode` codes: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 = 16 bpp, 5 = 32 bpp, 6 = 16 bpp 565, 7 = 12 bpp (stored in 16 bits). A word yields 32/bpp pixels, using 16 for the bpp of modes 4, 6 and 7.
- R4: With `be_bytes` = 0 and `be_pixels` = 0, pixel k of a word comes from bits [k*b +: b], where b is the storage size in bits.
- R5: With `be_bytes` = 1, byte order and pixel order are both big-endian: pixel k comes from bits [32-(k+1)*b +: b]. `be_pixels` is then ignored.
- R6: With `be_bytes` = 0 and `be_pixels` = 1, bytes stay little-endian. At depths below 8 bpp, pixels inside a byte are taken from the most significant end first. At 8 bpp and above, the result equals R4.
- R7: In modes 0 to 3, `pal_idx` carries the pixel value zero-extended to 8 bits, and the colour is `pal_color` = {c0, c1, c2}, with c0 in bits [23:16].
- R8: In mode 5, c0 = bits [7:0], c1 = [15:8] and c2 = [23:16] of the word. Bits [31:24] have no effect.
- R9: In mode 4 with `fmt16_sel` = 1, the layout is 5551: c0 = [4:0], c1 = [9:5], c2 = [14:10], and bit 15 has no effect. A 5-bit field v widens to {v, v[4:2]}.
- R10: Mode 6, and mode 4 with `fmt16_sel` equal to 0, 2 or 3, use 565: c0 = [4:0], c1 = [10:5] (6 bits, widened to {v, v[5:4]}), c2 = [15:11].
- R11: In mode 7, the layout is c0 = [3:0], c1 = [7:4], c2 = [11:8], each widened to {v, v}. Bits [15:12] have no effect.
- R12: `pix_data` is {c0, c1, c2} when the swap is off and {c2, c1, c0} when it is on. The swap equals `bgr_order`, except in mode 4 with `fmt16_sel` = 3, where it is always on.
- R13: All control inputs are sampled in the cycle a word is taken. Changing them while that word is held does not alter its remaining pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Depth code |
| bgr_order | input | 1 | Output component swap |
| be_bytes | input | 1 | Big-endian byte and pixel order |
| be_pixels | input | 1 | Big-endian pixel order within little-endian bytes |
| fmt16_sel | input | 2 | Board-level 16-bit layout selector |
| word_valid | input | 1 | Input word valid |
| word_ready | output | 1 | Input word ready |
| word_data | input | 32 | Framebuffer word |
| pal_idx | output | 8 | Palette lookup index |
| pal_color | input | 24 | Palette colour returned for `pal_idx` |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Output pixel ready |
| pix_data | output | 24 | Output pixel |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 8-bit channels and an 8-bit palette index. Under these values every depth code can be reached, from thirty-two pixels per word down to one, including the wrap of the pixel counter at the full word width. Controls change randomly every cycle, so the capture-with-word rule is exercised against the swap, ordering and 16-bit selector combinations. Ready and valid densities are varied, so that both stalls and back-to-back word handoffs on the last pixel occur.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int CH_W  = 8;
  localparam int PIX_W = 3 * CH_W;
  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    DM_1   = 3'd0,
    DM_2   = 3'd1,
    DM_4   = 3'd2,
    DM_8   = 3'd3,
    DM_16  = 3'd4,
    DM_32  = 3'd5,
    DM_565 = 3'd6,
    DM_12  = 3'd7
  } depth_e;

  typedef struct packed {
    depth_e     mode;
    logic       bgr;
    logic       be_bytes;
    logic       be_pix;
    logic [1:0] sel16;
  } cfg_t;

  // log2 of the storage bits per pixel
  function automatic logic [2:0] lg2_bpp(depth_e m);
    case (m)
      DM_1:    return 3'd0;
      DM_2:    return 3'd1;
      DM_4:    return 3'd2;
      DM_8:    return 3'd3;
      DM_32:   return 3'd5;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] widen5(logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [CH_W-1:0] widen4(logic [3:0] v);
    return {v, v};
  endfunction
endpackage

// File: rtl/fbu_word_slot.sv
module fbu_word_slot
  import fbu_pkg::*;
#(
  parameter  int WORD_W = 32,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  cfg_t              in_cfg,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] held_word,
  output cfg_t              held_cfg,
  output logic [CNT_W-1:0]  pix_cnt
);
  logic             full_q;
  logic [CNT_W-1:0] lim;
  logic             last, pop, load;

  always_comb begin
    lim      = CNT_W'((WORD_W >> lg2_bpp(held_cfg.mode)) - 1);
    last     = (pix_cnt == lim);
    pop      = full_q && out_ready;
    in_ready = !full_q || (pop && last);
    load     = in_valid && in_ready;
  end

  assign out_valid = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      pix_cnt   <= '0;
      held_word <= '0;
      held_cfg  <= '0;
    end else if (load) begin
      full_q    <= 1'b1;
      pix_cnt   <= '0;
      held_word <= in_word;
      held_cfg  <= in_cfg;
    end else if (pop) begin
      if (last) begin
        full_q  <= 1'b0;
        pix_cnt <= '0;
      end else begin
        pix_cnt <= pix_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbu_pixel_pick.sv
module fbu_pixel_pick
  import fbu_pkg::*;
#(
  parameter  int WORD_W  = 32,
  parameter  int FIELD_W = PIX_W,
  localparam int CNT_W   = $clog2(WORD_W),
  localparam int POS_W   = CNT_W + 1
) (
  input  logic [WORD_W-1:0]  word,
  input  depth_e             mode,
  input  logic               be_bytes,
  input  logic               be_pix,
  input  logic [CNT_W-1:0]   cnt,
  output logic [FIELD_W-1:0] field
);
  logic [2:0]        lg;
  logic [POS_W-1:0]  bits, base, pos;
  logic [WORD_W-1:0] mask;

  always_comb begin
    lg   = lg2_bpp(mode);
    bits = POS_W'(1) << lg;
    base = POS_W'(cnt) << lg;
    if (be_bytes)
      pos = POS_W'(WORD_W) - bits - base;
    else if (be_pix && (lg < 3'd3))
      pos = {base[POS_W-1:3], 3'b000} + POS_W'(8) - bits - POS_W'(base[2:0]);
    else
      pos = base;
    mask  = ~({WORD_W{1'b1}} << bits);
    field = FIELD_W'((word >> pos) & mask);
  end
endmodule

// File: rtl/fbu_color_expand.sv
module fbu_color_expand
  import fbu_pkg::*;
(
  input  logic [PIX_W-1:0] field,
  input  depth_e           mode,
  input  logic             bgr,
  input  logic [1:0]       sel16,
  output logic [IDX_W-1:0] pal_idx,
  input  logic [PIX_W-1:0] pal_color,
  output logic [PIX_W-1:0] pix
);
  logic [CH_W-1:0] c0, c1, c2;
  logic            swap;

  always_comb begin
    pal_idx = field[IDX_W-1:0];
    c0      = '0;
    c1      = '0;
    c2      = '0;
    swap    = bgr;
    case (mode)
      DM_1, DM_2, DM_4, DM_8: {c0, c1, c2} = pal_color;
      DM_32: begin
        c0 = field[7:0];
        c1 = field[15:8];
        c2 = field[23:16];
      end
      DM_12: begin
        c0 = widen4(field[3:0]);
        c1 = widen4(field[7:4]);
        c2 = widen4(field[11:8]);
      end
      DM_16: begin
        if (sel16 == 2'd1) begin
          c0 = widen5(field[4:0]);
          c1 = widen5(field[9:5]);
          c2 = widen5(field[14:10]);
        end else begin
          c0 = widen5(field[4:0]);
          c1 = widen6(field[10:5]);
          c2 = widen5(field[15:11]);
          if (sel16 == 2'd3) swap = 1'b1;
        end
      end
      default: begin
        c0 = widen5(field[4:0]);
        c1 = widen6(field[10:5]);
        c2 = widen5(field[15:11]);
      end
    endcase
    pix = swap ? {c2, c1, c0} : {c0, c1, c2};
  end
endmodule

// File: rtl/fb_unpack.sv
module fb_unpack
  import fbu_pkg::*;
#(
  parameter  int WORD_W = 32,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              bgr_order,
  input  logic              be_bytes,
  input  logic              be_pixels,
  input  logic [1:0]        fmt16_sel,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic [IDX_W-1:0]  pal_idx,
  input  logic [PIX_W-1:0]  pal_color,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [PIX_W-1:0]  pix_data
);
  cfg_t              in_cfg, held_cfg;
  logic [WORD_W-1:0] held_word;
  logic [CNT_W-1:0]  pix_cnt;
  logic [PIX_W-1:0]  field;
  depth_e            held_mode;

  always_comb begin
    in_cfg.mode     = depth_e'(mode);
    in_cfg.bgr      = bgr_order;
    in_cfg.be_bytes = be_bytes;
    in_cfg.be_pix   = be_pixels;
    in_cfg.sel16    = fmt16_sel;
  end

  assign held_mode = held_cfg.mode;

  fbu_word_slot #(.WORD_W(WORD_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (word_valid),
    .in_word   (word_data),
    .in_cfg    (in_cfg),
    .in_ready  (word_ready),
    .out_valid (pix_valid),
    .out_ready (pix_ready),
    .held_word (held_word),
    .held_cfg  (held_cfg),
    .pix_cnt   (pix_cnt)
  );

  fbu_pixel_pick #(.WORD_W(WORD_W), .FIELD_W(PIX_W)) u_pick (
    .word     (held_word),
    .mode     (held_mode),
    .be_bytes (held_cfg.be_bytes),
    .be_pix   (held_cfg.be_pix),
    .cnt      (pix_cnt),
    .field    (field)
  );

  fbu_color_expand u_expand (
    .field     (field),
    .mode      (held_mode),
    .bgr       (held_cfg.bgr),
    .sel16     (held_cfg.sel16),
    .pal_idx   (pal_idx),
    .pal_color (pal_color),
    .pix       (pix_data)
  );
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic        word_ready,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [23:0] pix_data,
  input logic [7:0]  pal_idx,
  input logic [2:0]  cur_mode
);
  AST_EMPTY_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> word_ready); // R1
  AST_LOAD_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready |=> pix_valid); // R1
  AST_STALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid); // R2
  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> $stable(pix_data)); // R2
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |-> !word_ready); // R2
  AST_ONE_BIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && (cur_mode == 3'd0) |-> (pal_idx[7:1] == 7'd0)); // R7
endmodule

bind fb_unpack fbu_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_data   (pix_data),
  .pal_idx    (pal_idx),
  .cur_mode   (held_mode)
);

// File: tb/fb_unpack_test.sv
module fb_unpack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic        bgr_order = 1'b0, be_bytes = 1'b0, be_pixels = 1'b0;
  logic [1:0]  fmt16_sel = '0;
  logic        word_valid = 1'b0, pix_ready = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready, pix_valid;
  logic [7:0]  pal_idx;
  logic [23:0] pal_color, pix_data;

  int total = 0;
  int bad = 0;
  logic [23:0] expq[$];
  string       tagq[$];

  always #10 clk = ~clk;

  // bench palette: a fixed function of the index
  assign pal_color = {pal_idx ^ 8'h5a, ~pal_idx, pal_idx + 8'd3};

  fb_unpack uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bgr_order(bgr_order),
    .be_bytes(be_bytes), .be_pixels(be_pixels), .fmt16_sel(fmt16_sel),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .pal_idx(pal_idx), .pal_color(pal_color), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bpp_of(int m);
    case (m)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      5: return 32;
      default: return 16;
    endcase
  endfunction

  // push the expected pixels of one accepted word (R3 .. R12)
  task automatic expect_word(logic [31:0] w, int m, bit bgr, bit beb, bit bep, int sel);
    int bpp = bpp_of(m);
    int n = 32 / bpp;
    logic [7:0] mb[4];
    string otag = beb ? "R5" : (bep ? "R6" : "R4");
    for (int i = 0; i < 4; i++) mb[i] = beb ? w[8*(3-i) +: 8] : w[8*i +: 8];
    for (int k = 0; k < n; k++) begin
      int v = 0;
      int a, g, c;
      bit swap;
      string mtag;
      if (bpp < 8) begin
        int per = 8 / bpp;
        int j = k % per;
        int sh = (beb || bep) ? 8 - bpp * (j + 1) : bpp * j;
        v = (int'(mb[k / per]) >> sh) & ((1 << bpp) - 1);
      end else begin
        int nb = bpp / 8;
        for (int i = 0; i < nb; i++) begin
          if (beb) v = (v << 8) | int'(mb[k*nb + i]);
          else     v = v | (int'(mb[k*nb + i]) << (8*i));
        end
      end
      swap = bgr || (m == 4 && sel == 3);
      if (m <= 3) begin
        mtag = "R7";
        a = (v ^ 'h5a) & 255; g = (~v) & 255; c = (v + 3) & 255;
      end else if (m == 5) begin
        mtag = "R8";
        a = v & 255; g = (v >> 8) & 255; c = (v >>> 16) & 255;
      end else if (m == 7) begin
        mtag = "R11";
        a = (v & 15) * 17; g = ((v >> 4) & 15) * 17; c = ((v >> 8) & 15) * 17;
      end else if (m == 4 && sel == 1) begin
        mtag = "R9";
        a = v & 31; g = (v >> 5) & 31; c = (v >> 10) & 31;
        a = (a << 3) | (a >> 2); g = (g << 3) | (g >> 2); c = (c << 3) | (c >> 2);
      end else begin
        mtag = "R10";
        a = v & 31; g = (v >> 5) & 63; c = (v >> 11) & 31;
        a = (a << 3) | (a >> 2); g = (g << 2) | (g >> 4); c = (c << 3) | (c >> 2);
      end
      expq.push_back(swap ? {c[7:0], g[7:0], a[7:0]} : {a[7:0], g[7:0], c[7:0]});
      tagq.push_back({mtag, " ", otag, " R3 R12 R13"});
    end
  endtask

  bit   prev_stall = 0;
  logic [23:0] prev_data = '0;

  // one cycle: drive at the falling edge, check before the rising edge
  task automatic step(int pv, int pr, int fix_mode, int fix_order);
    bit exp_valid, exp_wr;
    @(negedge clk);
    word_valid = (($urandom % 100) < pv);
    word_data  = $urandom;
    mode       = (fix_mode < 0) ? 3'($urandom % 8) : 3'(fix_mode);
    bgr_order  = 1'($urandom % 2);
    fmt16_sel  = 2'($urandom % 4);
    if (fix_order < 0) begin
      be_bytes  = 1'($urandom % 2);
      be_pixels = 1'($urandom % 2);
    end else begin
      be_bytes  = (fix_order == 1);
      be_pixels = (fix_order == 2);
    end
    pix_ready  = (($urandom % 100) < pr);
    #2;
    exp_valid = (expq.size() > 0);
    exp_wr    = (expq.size() == 0) || (pix_ready && expq.size() == 1);
    check(pix_valid == exp_valid, "R1 pix_valid", 32'(pix_valid), 32'(exp_valid));
    check(word_ready == exp_wr, "R1 R3 word_ready", 32'(word_ready), 32'(exp_wr));
    if (prev_stall)
      check(pix_data == prev_data && pix_valid, "R2 stalled pixel held", 32'(pix_data), 32'(prev_data));
    if (exp_valid && pix_valid)
      check(pix_data == expq[0], tagq[0], 32'(pix_data), 32'(expq[0]));
    prev_stall = pix_valid && !pix_ready;
    prev_data  = pix_data;
    if (exp_valid && pix_ready) begin
      void'(expq.pop_front());
      void'(tagq.pop_front());
    end
    if (word_valid && exp_wr)
      expect_word(word_data, int'(mode), bgr_order, be_bytes, be_pixels, int'(fmt16_sel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(pix_valid == 1'b0, "R1 reset pix_valid", 32'(pix_valid), 32'd0);
    check(word_ready == 1'b1, "R1 reset word_ready", 32'(word_ready), 32'd1);
    // every depth under each ordering, ready always high then stalling
    for (int m = 0; m < 8; m++)
      for (int o = 0; o < 3; o++) begin
        repeat (120) step(90, 100, m, o);
        repeat (120) step(60, 50, m, o);
      end
    // fully random controls, varied densities
    repeat (3000) step(50, 70, -1, -1);
    repeat (2000) step(100, 100, -1, -1);
    repeat (2000) step(20, 30, -1, -1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule